// File: doc/BRIEF.md
# Match-Compare Tick Timer

A free-running up-counter advances by one on every cycle in which the tick enable input is high, and rolls over from its all-ones value to zero. Software loads a single compare value. When a tick moves the counter onto that value, the block records the event in a status bit and drives a level interrupt, but only while the interrupt enable register holds a nonzero value. Software acknowledges the event by writing zero to the status register.

The timer sits on a simple synchronous word-wide register port with byte offsets. A read returns its data on the cycle after the request, together with a valid strobe. The counter width is a parameter and defaults to 32 bits. At the nominal 50 MHz tick rate, one tick is 20 ns. Narrower counters can be built for short periods or for verification.

Top module: `os_tick_timer`

## Requirements
- R1: After reset, the counter, compare value, status and interrupt enable registers are all zero, and `irq` is low.
- R2: The counter increments by one on each clock edge where `tick_en` is high, wraps from all-ones to zero, and holds its value when `tick_en` is low.
- R3: A read request (`req_valid` high, `req_write` low) sets `rd_valid` high for exactly the next cycle, with `rd_data` holding the addressed value. Offset 0x10 returns the counter, zero-extended to 32 bits.
- R4: A hit is a tick whose increment lands the counter on the compare value. On a hit with a nonzero interrupt enable register, status bit 0 becomes 1 and `irq` rises on the same edge.
- R5: A hit while the interrupt enable register is zero changes neither the status bit nor `irq`.
- R6: Writing zero to offset 0x14 clears status bit 0 and drops `irq`. A nonzero write to 0x14 is ignored. Status reads back at offset 0x14 as bit 0 of the word.
- R7: Offset 0x00 loads the compare value from the low counter-width bits of the write data. If the loaded value is at or below the current count, the next hit comes only after the counter wraps. An equal value gives a full counter period.
- R8: When a hit and a status clear fall on the same edge, the status bit stays set and `irq` stays high.
- R9: Reads of offset 0x00 and of any unmapped or unaligned offset return zero. Writes to unmapped offsets and to 0x10 have no effect.
- R10: Offset 0x1C stores all 32 bits of the interrupt enable register and reads them back unchanged. Any nonzero value enables the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance strobe |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Level interrupt, equal to status bit 0 |

## Verification
The hardest situation to reach is a hit after the counter wraps, because a full 32-bit period is far too long to run. The bench therefore builds the timer with a 10-bit counter. It then walks through full periods with the compare value equal to the count and below it. The same-edge race between a hit and a status clear is set up by stopping the counter one tick short of the compare value. The bench then issues the clearing write with `tick_en` high in that same cycle.

// File: rtl/os_tick_timer.sv
`timescale 1ns/1ps
module os_tick_timer #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        irq
);

  localparam logic [7:0] OFF_CMP = 8'h00;
  localparam logic [7:0] OFF_CNT = 8'h10;
  localparam logic [7:0] OFF_STS = 8'h14;
  localparam logic [7:0] OFF_IEN = 8'h1c;

  logic [CNT_W-1:0] cnt, cmp, cnt_inc;
  logic [31:0]      ien;
  logic             sts;
  logic             wr, rd, hit, clr;

  assign wr      = req_valid && req_write;
  assign rd      = req_valid && !req_write;
  assign cnt_inc = cnt + 1'b1;
  assign hit     = tick_en && (cnt_inc == cmp);
  assign clr     = wr && (req_addr == OFF_STS) && (req_wdata == 32'd0);
  assign irq     = sts;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (tick_en) cnt <= cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '0;
      ien <= '0;
    end else if (wr) begin
      if (req_addr == OFF_CMP) cmp <= req_wdata[CNT_W-1:0];
      if (req_addr == OFF_IEN) ien <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts <= 1'b0;
    else if (hit && (ien != 32'd0)) sts <= 1'b1;
    else if (clr) sts <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) begin
        case (req_addr)
          OFF_CNT: rd_data <= 32'(cnt);
          OFF_STS: rd_data <= {31'd0, sts};
          OFF_IEN: rd_data <= ien;
          default: rd_data <= 32'd0;
        endcase
      end else begin
        rd_data <= 32'd0;
      end
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && (&cnt)) |=> (cnt == '0));
  assert_rd_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
  assert_set_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (ien != 32'd0)) |=> irq);
  assert_rise_at_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cnt == cmp));
  assert_no_set_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (ien == 32'd0)) |=> !irq);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !irq);
  assert_race_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && hit && (ien != 32'd0)) |=> irq);
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr != OFF_CNT && req_addr != OFF_STS && req_addr != OFF_IEN)
      |=> (rd_data == 32'd0));

endmodule

// File: tb/os_tick_timer_tb.sv
`timescale 1ns/1ps
module os_tick_timer_tb;
  localparam int CW  = 10;
  localparam int MAX = 1 << CW;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid, irq;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  os_tick_timer #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check("R3 unexpected read", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic bus_rd(logic [7:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d, bit tk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; tick_en = tk;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tick_en = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq after reset", 32'(irq), 32'd0);
    bus_rd(8'h10, 0, "R1 counter reset");
    bus_rd(8'h14, 0, "R1 status reset");
    bus_rd(8'h1c, 0, "R1 enable reset");

    ticks(3);
    bus_rd(8'h10, 3, "R2 count after 3 ticks");
    repeat (4) @(negedge clk);
    bus_rd(8'h10, 3, "R2 count holds without tick");

    bus_wr(8'h00, 8, 0);
    ticks(5);
    check("R5 irq with enable zero", 32'(irq), 32'd0);
    bus_rd(8'h14, 0, "R5 status with enable zero");

    bus_wr(8'h1c, 32'h100, 0);
    bus_rd(8'h1c, 32'h100, "R10 enable readback");
    bus_wr(8'h00, 12, 0);
    ticks(3);
    check("R4 no irq before hit", 32'(irq), 32'd0);
    ticks(1);
    check("R4 irq on hit", 32'(irq), 32'd1);
    bus_rd(8'h14, 1, "R4 status on hit");

    bus_wr(8'h14, 32'h1, 0);
    bus_rd(8'h14, 1, "R6 nonzero write ignored");
    bus_wr(8'h14, 0, 0);
    check("R6 irq cleared", 32'(irq), 32'd0);
    bus_rd(8'h14, 0, "R6 status cleared");

    bus_rd(8'h00, 0, "R9 compare reads zero");
    bus_rd(8'h08, 0, "R9 unmapped read");
    bus_wr(8'h08, 32'hffff, 0);
    bus_wr(8'h10, 32'h55, 0);
    bus_rd(8'h10, 12, "R9 counter untouched by writes");
    bus_rd(8'h1c, 32'h100, "R9 enable untouched by unmapped write");

    bus_wr(8'h00, 12, 0);
    ticks(MAX - 1);
    check("R7 equal compare no early hit", 32'(irq), 32'd0);
    ticks(1);
    check("R7 equal compare hit after full period", 32'(irq), 32'd1);
    bus_wr(8'h14, 0, 0);
    bus_wr(8'h00, 5, 0);
    ticks(MAX - 12 + 5 - 1);
    check("R7 lower compare no early hit", 32'(irq), 32'd0);
    ticks(1);
    check("R7 lower compare hit after wrap", 32'(irq), 32'd1);
    bus_rd(8'h10, 5, "R7 count at hit");

    bus_wr(8'h00, 7, 0);
    ticks(1);
    bus_wr(8'h14, 0, 1);
    check("R8 irq kept on race", 32'(irq), 32'd1);
    bus_rd(8'h14, 1, "R8 status kept on race");
    bus_wr(8'h14, 0, 0);
    check("R6 clear after race", 32'(irq), 32'd0);

    ticks(MAX - 8);
    bus_rd(8'h10, MAX - 1, "R2 count at all-ones");
    ticks(1);
    bus_rd(8'h10, 0, "R2 wrap to zero");
    check("R2 no spurious irq", 32'(irq), 32'd0);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) check("R3 missing read data", 32'(exp_q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule